// File: doc/BRIEF.md
# Reorder-Buffer Rename and Commit Unit

This block renames one instruction per cycle for an out-of-order core in which committed register values are held in a small architectural register file and speculative results exist only in the data array of a reorder buffer. Every architectural register has an alias entry. The entry either says "the value is committed" or names the reorder buffer slot that will produce the newest value. At rename, each source operand is resolved through this entry. A committed value is read from the architectural file. A produced value is read from the buffer slot. A value that is not yet produced comes back as a slot tag to wait on. The destination of the renamed instruction is then pointed at the slot just allocated for it.

Execution units return results through a writeback port, which fills the slot and marks it ready. A retire request commits the oldest slot once its result is present. Commit copies the result into the architectural file and, if the alias entry still names that slot, turns the entry back to "committed". A mispredicted branch is handled in order: when the branch retires with the flush flag set, every younger slot is discarded and every alias entry returns to the architectural file.

Top module: `rob_rename_commit`

## Requirements
- R1: After reset every architectural register holds zero and resolves to the architectural file, the buffer is empty, `ren_ready` is 1 and the first allocated tag is 0.
- R2: A rename is accepted when `ren_valid` and `ren_ready` are both 1 in a cycle. `ren_tag` always shows the slot the next accepted rename will take, and tags advance by one, modulo the buffer depth, per accepted rename.
- R3: A source whose alias entry is committed returns `src_pend`=0, `src_ready`=1, `src_tag`=0 and the architectural file value.
- R4: A source whose alias entry names a slot returns `src_pend`=1 and that slot in `src_tag`. If the slot's result is present, it returns `src_ready`=1 and the result. Otherwise it returns `src_ready`=0 and `src_value`=0.
- R5: A writeback to a slot in the same cycle as a lookup of that slot is forwarded, so the lookup returns `src_ready`=1 and the writeback data.
- R6: `ret_fire` is 1 exactly when `ret_req` is 1, the buffer is non-empty and the oldest slot's stored result is present. On the next edge, a firing retire with a destination copies the result into the architectural file.
- R7: A retire turns its destination's alias entry back to committed only when that entry still names the retiring slot. A younger writer's mapping is kept.
- R8: A retire with `ret_flush`=1 discards all younger slots and returns every alias entry to the architectural file. No rename is accepted in that cycle, and the next allocated tag is the slot after the retired one.
- R9: When the buffer holds its full depth of slots, `ren_ready` is 0 and a rename has no effect.
- R10: The sources of an instruction are resolved through the alias entries as they were before that instruction's own destination is mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_src | input | NUM_SRC x AW | Source register numbers |
| ren_dst_en | input | 1 | Instruction writes a destination |
| ren_dst | input | AW | Destination register number |
| ren_ready | output | 1 | A rename can be accepted this cycle |
| ren_tag | output | TW | Slot given to the next accepted rename |
| src_pend | output | NUM_SRC | Source maps to a buffer slot |
| src_ready | output | NUM_SRC | Source value is available |
| src_tag | output | NUM_SRC x TW | Slot to wait on (0 when committed) |
| src_value | output | NUM_SRC x DATA_W | Resolved operand value (0 when not available) |
| wb_valid | input | 1 | Result writeback |
| wb_tag | input | TW | Slot receiving the result |
| wb_data | input | DATA_W | Result value |
| ret_req | input | 1 | Request to retire the oldest slot |
| ret_flush | input | 1 | Retiring instruction was a mispredicted branch |
| ret_fire | output | 1 | Oldest slot retires this cycle |

## Verification
A corrupted alias entry appears in the same cycle as a wrong `src_pend` or `src_tag` for any later lookup of that register. A lost ready bit or a wrong data slot shows as a wrong `src_ready` or value, either at once through a lookup or later through a stalled `ret_fire`. A wrong commit stays hidden until the register is read again after its alias entry returns to committed. Pointer or count errors show at once in `ren_tag`, or in `ren_ready` when the buffer is near full. The bench therefore keeps the architecture register count small and the buffer shallow, so that registers are reused and the buffer fills up often.

// File: rtl/rr_pkg.sv
package rr_pkg;
   // Classification of one source operand at rename
   typedef enum logic [1:0] {
      SRC_ARCH = 2'd0,   // committed value in the architectural file
      SRC_WAIT = 2'd1,   // producer slot has no result yet
      SRC_ROB  = 2'd2    // producer slot already holds its result
   } src_kind_e;
endpackage

// File: rtl/rr_arch_file.sv
module rr_arch_file #(
   parameter int NUM_ARCH = 32,
   parameter int DATA_W   = 32,
   parameter int NUM_RD   = 2,
   localparam int AW      = $clog2(NUM_ARCH)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [AW-1:0]                   waddr,
   input  logic [DATA_W-1:0]               wdata,
   input  logic [NUM_RD-1:0][AW-1:0]       raddr,
   output logic [NUM_RD-1:0][DATA_W-1:0]   rdata
);
   logic [DATA_W-1:0] regs_q [NUM_ARCH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ARCH; i++) regs_q[i] <= '0;
      end else if (we) begin
         regs_q[waddr] <= wdata;
      end
   end

   for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
      assign rdata[g] = regs_q[raddr[g]];
   end
endmodule

// File: rtl/rr_alias_table.sv
module rr_alias_table #(
   parameter int NUM_ARCH = 32,
   parameter int TW       = 7,
   parameter int NUM_RD   = 2,
   localparam int AW      = $clog2(NUM_ARCH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        set_en,
   input  logic [AW-1:0]               set_reg,
   input  logic [TW-1:0]               set_tag,
   input  logic                        clr_en,
   input  logic [AW-1:0]               clr_reg,
   input  logic [TW-1:0]               clr_tag,
   input  logic                        flush,
   input  logic [NUM_RD-1:0][AW-1:0]   rd_reg,
   output logic [NUM_RD-1:0]           rd_pend,
   output logic [NUM_RD-1:0][TW-1:0]   rd_tag
);
   logic [NUM_ARCH-1:0] pend_q;
   logic [TW-1:0]       tag_q [NUM_ARCH];

   // pend bit low means the register now resolves to the committed file
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (flush) begin
         pend_q <= '0;
      end else begin
         if (clr_en && pend_q[clr_reg] && (tag_q[clr_reg] == clr_tag))
            pend_q[clr_reg] <= 1'b0;
         if (set_en)
            pend_q[set_reg] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (set_en) tag_q[set_reg] <= set_tag;
   end

   for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
      assign rd_pend[g] = pend_q[rd_reg[g]];
      assign rd_tag[g]  = tag_q[rd_reg[g]];
   end

   // R8
   flush_clears_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (pend_q == '0));

   // R7
   younger_map_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en && !flush && pend_q[clr_reg] && (tag_q[clr_reg] != clr_tag))
      |=> pend_q[$past(clr_reg)]);

   // R8
   no_set_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(flush && set_en));
endmodule

// File: rtl/rr_rob_store.sv
module rr_rob_store #(
   parameter int DEPTH   = 128,
   parameter int DATA_W  = 32,
   parameter int AW      = 5,
   parameter int NUM_RD  = 2,
   localparam int TW     = $clog2(DEPTH)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            alloc,
   input  logic [AW-1:0]                   alloc_dst,
   input  logic                            alloc_has_dst,
   input  logic                            wb_valid,
   input  logic [TW-1:0]                   wb_tag,
   input  logic [DATA_W-1:0]               wb_data,
   input  logic                            retire,
   input  logic                            flush,
   input  logic [NUM_RD-1:0][TW-1:0]       rd_tag,
   output logic [NUM_RD-1:0]               rd_ready,
   output logic [NUM_RD-1:0][DATA_W-1:0]   rd_data,
   output logic [TW-1:0]                   tail,
   output logic [TW-1:0]                   head,
   output logic                            full,
   output logic                            empty,
   output logic                            head_ready,
   output logic [AW-1:0]                   head_dst,
   output logic                            head_has_dst,
   output logic [DATA_W-1:0]               head_data
);
   localparam logic [TW:0] FULL_CNT = (TW+1)'(DEPTH);

   logic [DATA_W-1:0] data_q [DEPTH];
   logic [AW-1:0]     dst_q  [DEPTH];
   logic [DEPTH-1:0]  has_q;
   logic [DEPTH-1:0]  rdy_q;
   logic [TW-1:0]     head_q, tail_q;
   logic [TW:0]       cnt_q;

   always_ff @(posedge clk) begin
      if (wb_valid) data_q[wb_tag] <= wb_data;
      if (alloc) begin
         dst_q[tail_q] <= alloc_dst;
         has_q[tail_q] <= alloc_has_dst;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q <= '0;
      end else begin
         if (wb_valid) rdy_q[wb_tag] <= 1'b1;
         if (alloc)    rdy_q[tail_q] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         head_q <= head_q + 1'b1;
         tail_q <= head_q + 1'b1;
         cnt_q  <= '0;
      end else begin
         if (retire) head_q <= head_q + 1'b1;
         if (alloc)  tail_q <= tail_q + 1'b1;
         case ({alloc, retire})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign tail         = tail_q;
   assign head         = head_q;
   assign full         = (cnt_q == FULL_CNT);
   assign empty        = (cnt_q == '0);
   assign head_ready   = rdy_q[head_q];
   assign head_dst     = dst_q[head_q];
   assign head_has_dst = has_q[head_q];
   assign head_data    = data_q[head_q];

   // read ports forward a same-cycle writeback
   for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
      logic fwd;
      assign fwd         = wb_valid && (wb_tag == rd_tag[g]);
      assign rd_ready[g] = fwd || rdy_q[rd_tag[g]];
      assign rd_data[g]  = fwd ? wb_data : data_q[rd_tag[g]];
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);

   // R9
   no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !full);

   // R6
   retire_needs_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> (!empty && rdy_q[head_q]));

   // R8
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && (head_q == tail_q)));

   // R2
   tail_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc && !flush) |=> (tail_q == $past(tail_q) + 1'b1));
endmodule

// File: rtl/rob_rename_commit.sv
module rob_rename_commit #(
   parameter int NUM_ARCH  = 32,
   parameter int ROB_DEPTH = 128,
   parameter int DATA_W    = 32,
   parameter int NUM_SRC   = 2,
   localparam int AW       = $clog2(NUM_ARCH),
   localparam int TW       = $clog2(ROB_DEPTH)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             ren_valid,
   input  logic [NUM_SRC-1:0][AW-1:0]       ren_src,
   input  logic                             ren_dst_en,
   input  logic [AW-1:0]                    ren_dst,
   output logic                             ren_ready,
   output logic [TW-1:0]                    ren_tag,
   output logic [NUM_SRC-1:0]               src_pend,
   output logic [NUM_SRC-1:0]               src_ready,
   output logic [NUM_SRC-1:0][TW-1:0]       src_tag,
   output logic [NUM_SRC-1:0][DATA_W-1:0]   src_value,
   input  logic                             wb_valid,
   input  logic [TW-1:0]                    wb_tag,
   input  logic [DATA_W-1:0]                wb_data,
   input  logic                             ret_req,
   input  logic                             ret_flush,
   output logic                             ret_fire
);
   import rr_pkg::*;

   if ((ROB_DEPTH < 2) || ((ROB_DEPTH & (ROB_DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("ROB_DEPTH must be a power of two of at least 2");
   end
   if ((NUM_ARCH < 2) || ((NUM_ARCH & (NUM_ARCH - 1)) != 0)) begin : g_bad_arch
      $error("NUM_ARCH must be a power of two of at least 2");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("NUM_SRC must be at least 1");
   end

   logic                            full, empty, head_ready, head_has_dst;
   logic [TW-1:0]                   tail, head;
   logic [AW-1:0]                   head_dst;
   logic [DATA_W-1:0]               head_data;
   logic                            flush, alloc;
   logic [NUM_SRC-1:0]              al_pend;
   logic [NUM_SRC-1:0][TW-1:0]      al_tag;
   logic [NUM_SRC-1:0]              rob_rdy;
   logic [NUM_SRC-1:0][DATA_W-1:0]  rob_val;
   logic [NUM_SRC-1:0][DATA_W-1:0]  arf_val;

   assign ret_fire  = ret_req && !empty && head_ready;
   assign flush     = ret_fire && ret_flush;
   assign ren_ready = !full && !flush;
   assign alloc     = ren_valid && ren_ready;
   assign ren_tag   = tail;

   rr_alias_table #(.NUM_ARCH(NUM_ARCH), .TW(TW), .NUM_RD(NUM_SRC)) i_alias (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (alloc && ren_dst_en),
      .set_reg (ren_dst),
      .set_tag (tail),
      .clr_en  (ret_fire && head_has_dst),
      .clr_reg (head_dst),
      .clr_tag (head),
      .flush   (flush),
      .rd_reg  (ren_src),
      .rd_pend (al_pend),
      .rd_tag  (al_tag)
   );

   rr_rob_store #(.DEPTH(ROB_DEPTH), .DATA_W(DATA_W), .AW(AW), .NUM_RD(NUM_SRC)) i_rob (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc        (alloc),
      .alloc_dst    (ren_dst),
      .alloc_has_dst(ren_dst_en),
      .wb_valid     (wb_valid),
      .wb_tag       (wb_tag),
      .wb_data      (wb_data),
      .retire       (ret_fire),
      .flush        (flush),
      .rd_tag       (al_tag),
      .rd_ready     (rob_rdy),
      .rd_data      (rob_val),
      .tail         (tail),
      .head         (head),
      .full         (full),
      .empty        (empty),
      .head_ready   (head_ready),
      .head_dst     (head_dst),
      .head_has_dst (head_has_dst),
      .head_data    (head_data)
   );

   rr_arch_file #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .NUM_RD(NUM_SRC)) i_arf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ret_fire && head_has_dst),
      .waddr (head_dst),
      .wdata (head_data),
      .raddr (ren_src),
      .rdata (arf_val)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      src_kind_e kind;
      always_comb begin
         if (!al_pend[g])     kind = SRC_ARCH;
         else if (rob_rdy[g]) kind = SRC_ROB;
         else                 kind = SRC_WAIT;
      end
      always_comb begin
         unique case (kind)
            SRC_ARCH: begin
               src_pend[g]  = 1'b0;
               src_ready[g] = 1'b1;
               src_tag[g]   = '0;
               src_value[g] = arf_val[g];
            end
            SRC_ROB: begin
               src_pend[g]  = 1'b1;
               src_ready[g] = 1'b1;
               src_tag[g]   = al_tag[g];
               src_value[g] = rob_val[g];
            end
            default: begin
               src_pend[g]  = 1'b1;
               src_ready[g] = 1'b0;
               src_tag[g]   = al_tag[g];
               src_value[g] = '0;
            end
         endcase
      end

      // R5
      wb_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (src_pend[g] && wb_valid && (wb_tag == src_tag[g]))
         |-> (src_ready[g] && (src_value[g] == wb_data)));
   end

   // R8
   no_rename_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_fire && ret_flush) |-> !ren_ready);

   // R6
   retire_writes_arf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_fire && head_has_dst) |=> (i_arf.regs_q[$past(head_dst)] == $past(head_data)));
endmodule

// File: tb/test_rob_rename_commit.sv
module test_rob_rename_commit;
   localparam int NA = 8;
   localparam int RD = 8;
   localparam int DW = 16;
   localparam int NS = 2;
   localparam int AW = 3;
   localparam int TW = 3;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic                      ren_valid = 1'b0;
   logic [NS-1:0][AW-1:0]     ren_src = '0;
   logic                      ren_dst_en = 1'b0;
   logic [AW-1:0]             ren_dst = '0;
   logic                      ren_ready;
   logic [TW-1:0]             ren_tag;
   logic [NS-1:0]             src_pend, src_ready;
   logic [NS-1:0][TW-1:0]     src_tag;
   logic [NS-1:0][DW-1:0]     src_value;
   logic                      wb_valid = 1'b0;
   logic [TW-1:0]             wb_tag = '0;
   logic [DW-1:0]             wb_data = '0;
   logic                      ret_req = 1'b0;
   logic                      ret_flush = 1'b0;
   logic                      ret_fire;

   always #10 clk = ~clk;

   rob_rename_commit #(.NUM_ARCH(NA), .ROB_DEPTH(RD), .DATA_W(DW), .NUM_SRC(NS)) i_rob_rename_commit (
      .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src(ren_src),
      .ren_dst_en(ren_dst_en), .ren_dst(ren_dst), .ren_ready(ren_ready), .ren_tag(ren_tag),
      .src_pend(src_pend), .src_ready(src_ready), .src_tag(src_tag), .src_value(src_value),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
      .ret_req(ret_req), .ret_flush(ret_flush), .ret_fire(ret_fire)
   );

   // behavioural reference state
   int arf [NA];
   bit mp  [NA];
   int mt  [NA];
   int rdat [RD];
   bit rrdy [RD];
   int rdst [RD];
   bit rhas [RD];
   int head, tail, cnt;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step(input bit rv, input int s0, input int s1, input int d, input bit hd,
                       input bit wv, input int wt, input int wd, input bit rq, input bit fl,
                       input string lab);
      bit e_full, e_fire, e_flush, e_rdy, acc;
      int srcs [NS];
      @(negedge clk);
      srcs[0] = s0; srcs[1] = s1;
      ren_valid = rv; ren_src[0] = AW'(s0); ren_src[1] = AW'(s1);
      ren_dst = AW'(d); ren_dst_en = hd;
      wb_valid = wv; wb_tag = TW'(wt); wb_data = DW'(wd);
      ret_req = rq; ret_flush = fl;
      #2;
      e_full  = (cnt == RD);
      e_fire  = rq && (cnt > 0) && rrdy[head];
      e_flush = e_fire && fl;
      e_rdy   = !e_full && !e_flush;
      chk(ren_ready == e_rdy, (lab != "") ? lab : (e_full ? "R9" : "R2"), "ren_ready", int'(ren_ready), int'(e_rdy));
      chk(int'(ren_tag) == tail, (lab != "") ? lab : "R2", "ren_tag", int'(ren_tag), tail);
      chk(ret_fire == e_fire, (lab != "") ? lab : "R6", "ret_fire", int'(ret_fire), int'(e_fire));
      for (int k = 0; k < NS; k++) begin
         int r, ep, er, et, ev;
         bit fw;
         string req;
         r = srcs[k];
         fw = 1'b0;
         if (!mp[r]) begin
            ep = 0; er = 1; et = 0; ev = arf[r]; req = "R3";
         end else begin
            ep = 1; et = mt[r];
            fw = wv && (wt == et);
            if (rrdy[et] || fw) begin
               er = 1; ev = fw ? wd : rdat[et];
               req = (fw && !rrdy[et]) ? "R5" : "R4";
            end else begin
               er = 0; ev = 0; req = "R4";
            end
         end
         if (rv && hd && (d == r)) req = "R10";
         if (lab != "") req = lab;
         chk(int'(src_pend[k]) == ep, req, "src_pend", int'(src_pend[k]), ep);
         chk(int'(src_ready[k]) == er, req, "src_ready", int'(src_ready[k]), er);
         chk(int'(src_tag[k]) == et, req, "src_tag", int'(src_tag[k]), et);
         chk(int'(src_value[k]) == ev, req, "src_value", int'(src_value[k]), ev);
      end
      // next state of the reference
      acc = rv && e_rdy;
      if (e_fire) begin
         if (rhas[head]) begin
            arf[rdst[head]] = rdat[head];
            if (mp[rdst[head]] && mt[rdst[head]] == head) mp[rdst[head]] = 1'b0;
         end
         head = (head + 1) % RD;
         cnt--;
         if (e_flush) begin
            for (int i = 0; i < NA; i++) mp[i] = 1'b0;
            tail = head;
            cnt = 0;
         end
      end
      if (wv) begin
         rrdy[wt] = 1'b1;
         rdat[wt] = wd;
      end
      if (acc) begin
         rrdy[tail] = 1'b0;
         rdst[tail] = d;
         rhas[tail] = hd;
         if (hd) begin
            mp[d] = 1'b1;
            mt[d] = tail;
         end
         tail = (tail + 1) % RD;
         cnt++;
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NA; i++) begin arf[i] = 0; mp[i] = 1'b0; mt[i] = 0; end
      for (int i = 0; i < RD; i++) begin rdat[i] = 0; rrdy[i] = 1'b0; rdst[i] = 0; rhas[i] = 1'b0; end
      head = 0; tail = 0; cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state seen by the first rename (r1 -> slot 0)
      step(1, 1, 2, 1, 1, 0, 0, 0, 0, 0, "R1");
      // R5: r1 -> slot 1 while slot 0 is written back in the same cycle
      step(1, 1, 1, 1, 1, 1, 0, 'h55, 0, 0, "R5");
      // R7: retire slot 0, r1 must stay on slot 1
      step(0, 1, 1, 0, 0, 0, 0, 0, 1, 0, "R7");
      step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
      // R6: produce and retire slot 1, then r1 reads the committed value
      step(0, 1, 0, 0, 0, 1, 1, 'h77, 0, 0, "");
      step(0, 1, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
      step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
      // R8: r3 -> slot 2, r4 -> slot 3, slot 2 is a mispredicted branch
      step(1, 3, 4, 3, 1, 0, 0, 0, 0, 0, "");
      step(1, 3, 4, 4, 1, 1, 2, 'h1234, 0, 0, "");
      step(1, 3, 4, 5, 1, 0, 0, 0, 1, 1, "R8");
      step(0, 3, 4, 0, 0, 0, 0, 0, 0, 0, "R8");
      step(0, 5, 1, 0, 0, 0, 0, 0, 0, 0, "R8");

      // mixed traffic with alternating fill and drain phases
      for (int c = 0; c < 3000; c++) begin
         bit rv, hd, wv, rq, fl, fill;
         int wt, wd;
         fill = ((c / 250) % 2) == 0;
         rv = fill ? ($urandom % 4 != 0) : ($urandom % 3 == 0);
         hd = ($urandom % 5 != 0);
         wv = 1'b0; wt = 0;
         wd = $urandom % 65536;
         if (cnt > 0) begin
            int t;
            t = (head + ($urandom % cnt)) % RD;
            if (!rrdy[t] && ($urandom % 3 != 0)) begin wv = 1'b1; wt = t; end
         end
         rq = fill ? ($urandom % 5 == 0) : ($urandom % 4 != 0);
         fl = ($urandom % 25 == 0);
         step(rv, $urandom % NA, $urandom % NA, $urandom % NA, hd, wv, wt, wd, rq, fl, "");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule